// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block picks, on every clock, which of four transmit queues may begin sending a frame. In the time-aware mode it runs a repeating gate cycle that starts from a programmable base time on a free-running nanosecond counter. Inside each cycle, every queue has its own open window. A queue that is asking to send can be granted only while its window is open. Optional rules also hold back a frame that would run past the window end or past the cycle boundary. A queue can additionally be made to wait for the launch time of its head frame.

Software writes new window offsets and a new cycle length into staging registers. It then writes the base time, seconds word first and nanoseconds word second. The nanoseconds write arms the staged schedule. The schedule takes over once the counter reaches the armed base. A base that is already in the past is moved forward to the next cycle boundary that lies after the current time. Among the queues that pass every rule, a four-slot priority map decides the winner. In the plain priority mode, only that map is used. The result leaves the block as a registered one-hot grant with a start strobe.

Top module: `tsn_gate_sched`

## Requirements
- R1: After reset, grant and start are 0. Every window (staged and active) opens at 0 and closes at 1,000,000,000 ns. The cycle is 1,000,000,000 ns, the active base is 0, the mode word is 0 and the priority map is the identity map.
- R2: When mode bit 0 is 0 (plain priority mode), the grant goes to the highest-priority requesting queue. Windows, strict rules and launch times have no effect in this mode.
- R3: In the map word, slot k occupies bits [2k+1:2k] and holds a queue number. Slot 0 has the highest priority. The reset value is 0xE4, which places queue k in slot k.
- R4: When mode bit 0 is 1, a requesting queue q is eligible only while open_q <= offset < close_q. Here offset = (now − active base) mod cycle. The nanosecond input must move forward by less than one cycle per clock.
- R5: With mode bit 1 (strict end) set, a queue is eligible only if offset + frame duration <= close_q.
- R6: With mode bit 2 (strict cycle) set, a queue is eligible only if offset + frame duration <= cycle.
- R7: With mode bit 3+q set, queue q is eligible only once now + transmit offset >= that queue's launch time.
- R8: The transmit offset depends on the speed code: 0 (10 Mb/s) gives 9600 ns, 1 (100 Mb/s) gives 960 ns, 2 (1000 Mb/s) gives 160 ns and 3 (2500 Mb/s) gives 64 ns. Codes 4 to 7 give 0.
- R9: Frame duration uses B = length + 20 bytes. It is B×800 ns for code 0, B×80 ns for code 1, B×8 ns for code 2 and ceil(B×16/5) ns for code 3. Any other code uses the 10 Mb/s figure.
- R10: A write to the base-nanoseconds word arms the staged windows and cycle. They are copied into the active set at the first clock edge where now >= the armed base. The grant decided at that edge still uses the old set. From then on, offsets count from the armed base.
- R11: Let the requested base be seconds×1,000,000,000 + nanoseconds. If it is earlier than now when armed, the armed base becomes base + (floor((now − base)/cycle) + 1)×cycle. Otherwise the armed base is the requested base itself.
- R12: The grant is one-hot or zero and appears one clock after the requests it answers. Start is high exactly when the grant is non-zero.
- R13: Register addresses are as follows: 0–3 set the open offset of queues 0–3, 4–7 set the close offsets, 8 the cycle, 9 base seconds, 10 base nanoseconds (commit), 11 the mode word and 12 the map. A write lands on the clock edge where cfg_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| now_ns | input | 64 | Free-running nanosecond time |
| link_speed | input | 3 | Link speed code |
| q_req | input | 4 | Per-queue transmit request |
| q_len | input | 4×16 | Per-queue head frame length in bytes |
| q_launch | input | 4×64 | Per-queue head frame launch time |
| grant | output | 4 | One-hot transmit grant |
| start | output | 1 | Frame start strobe |

## Verification
The bench arms a base that lies in the past. It then checks that the old schedule still governs just before the realigned boundary and that the new windows govern just after it. A design that skipped realignment, or rounded to the wrong boundary, would grant queue 1 at the wrong offsets. Sweeps over every request pattern, several link speeds and every mix of strict-end and strict-cycle rules catch windows that are off by one at either edge, duration arithmetic that is wrong (especially the rounded-up 2500 Mb/s case) and priority decoding that is wrong. A second commit with a longer cycle and a future base shows whether a design switches schedules too early. Launch-time probes placed one nanosecond either side of the threshold expose a transmit offset chosen for the wrong speed, or an unknown speed code that is not treated as zero.

// File: rtl/tsn_gate_pkg.sv
package tsn_gate_pkg;

    localparam int TSN_NQ = 4;
    localparam int WIRE_OVERHEAD = 20;
    localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;

    localparam logic [2:0] SPD_10   = 3'd0;
    localparam logic [2:0] SPD_100  = 3'd1;
    localparam logic [2:0] SPD_1000 = 3'd2;
    localparam logic [2:0] SPD_2500 = 3'd3;

    // mode word: bit0 gating on, bit1 strict end, bit2 strict cycle, bits 3+q launch gate
    typedef struct packed {
        logic [TSN_NQ-1:0] launch_en;
        logic              strict_cycle;
        logic              strict_end;
        logic              tsn_en;
    } mode_t;

    function automatic logic [31:0] frame_ns(input logic [31:0] bytes, input logic [2:0] spd);
        logic [31:0] b;
        b = bytes + 32'(WIRE_OVERHEAD);
        case (spd)
            SPD_100:  return b * 32'd80;
            SPD_1000: return b << 3;
            SPD_2500: return (b * 32'd16 + 32'd4) / 32'd5;
            default:  return b * 32'd800;
        endcase
    endfunction

    function automatic logic [15:0] tx_offset(input logic [2:0] spd);
        case (spd)
            SPD_10:   return 16'd9600;
            SPD_100:  return 16'd960;
            SPD_1000: return 16'd160;
            SPD_2500: return 16'd64;
            default:  return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/tsn_sched_regs.sv
module tsn_sched_regs
    import tsn_gate_pkg::*;
#(
    parameter int NQ     = TSN_NQ,
    parameter int TIME_W = 64,
    parameter int OFF_W  = 32,
    parameter int AW     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [AW-1:0]                 cfg_addr,
    input  logic [OFF_W-1:0]              cfg_wdata,
    input  logic [TIME_W-1:0]             now_ns,
    output logic [NQ-1:0][OFF_W-1:0]      act_open,
    output logic [NQ-1:0][OFF_W-1:0]      act_close,
    output logic [OFF_W-1:0]              act_cycle,
    output logic [OFF_W-1:0]              cur_off,
    output mode_t                         mode,
    output logic [NQ-1:0][$clog2(NQ)-1:0] prio_map,
    output logic [TIME_W-1:0]             pend_base
);
    localparam int QW = $clog2(NQ);
    localparam logic [AW-1:0] A_CYCLE = AW'(2*NQ);
    localparam logic [AW-1:0] A_BSEC  = AW'(2*NQ + 1);
    localparam logic [AW-1:0] A_BNS   = AW'(2*NQ + 2);
    localparam logic [AW-1:0] A_MODE  = AW'(2*NQ + 3);
    localparam logic [AW-1:0] A_MAP   = AW'(2*NQ + 4);
    localparam logic [OFF_W-1:0] ONE_SEC = OFF_W'(NS_PER_SEC);

    logic [NQ-1:0][OFF_W-1:0] stg_open, stg_close;
    logic [OFF_W-1:0]         stg_cycle, stg_sec;
    logic [TIME_W-1:0]        req_base, cyc_eff, aligned_base, cyc_start, raw_off;
    logic                     pend_valid, commit, activate, roll;

    assign commit   = cfg_we && (cfg_addr == A_BNS);
    assign activate = pend_valid && (now_ns >= pend_base);
    assign raw_off  = now_ns - cyc_start;
    assign roll     = raw_off >= TIME_W'(act_cycle);
    assign cur_off  = roll ? OFF_W'(raw_off - TIME_W'(act_cycle)) : OFF_W'(raw_off);

    // push a past base forward to the first cycle boundary after now
    always_comb begin
        req_base = TIME_W'(stg_sec) * TIME_W'(NS_PER_SEC) + TIME_W'(cfg_wdata);
        cyc_eff  = (stg_cycle == '0) ? TIME_W'(1) : TIME_W'(stg_cycle);
        if (now_ns > req_base)
            aligned_base = now_ns + cyc_eff - ((now_ns - req_base) % cyc_eff);
        else
            aligned_base = req_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NQ; q++) begin
                stg_open[q]  <= '0;
                stg_close[q] <= ONE_SEC;
                act_open[q]  <= '0;
                act_close[q] <= ONE_SEC;
            end
            for (int k = 0; k < NQ; k++) prio_map[k] <= QW'(k);
            stg_cycle  <= ONE_SEC;
            act_cycle  <= ONE_SEC;
            stg_sec    <= '0;
            cyc_start  <= '0;
            pend_valid <= 1'b0;
            pend_base  <= '0;
            mode       <= '0;
        end else begin
            if (cfg_we) begin
                for (int q = 0; q < NQ; q++) begin
                    if (cfg_addr == AW'(q))      stg_open[q]  <= cfg_wdata;
                    if (cfg_addr == AW'(NQ + q)) stg_close[q] <= cfg_wdata;
                end
                if (cfg_addr == A_CYCLE) stg_cycle <= cfg_wdata;
                if (cfg_addr == A_BSEC)  stg_sec   <= cfg_wdata;
                if (cfg_addr == A_MODE)  mode      <= mode_t'(cfg_wdata[$bits(mode_t)-1:0]);
                if (cfg_addr == A_MAP)
                    for (int k = 0; k < NQ; k++) prio_map[k] <= cfg_wdata[k*QW +: QW];
            end
            if (activate) begin
                act_open   <= stg_open;
                act_close  <= stg_close;
                act_cycle  <= stg_cycle;
                cyc_start  <= pend_base;
                pend_valid <= 1'b0;
            end else if (roll) begin
                cyc_start <= cyc_start + TIME_W'(act_cycle);
            end
            if (commit) begin
                pend_valid <= 1'b1;
                pend_base  <= aligned_base;
            end
        end
    end

endmodule

// File: rtl/tsn_gate_eval.sv
module tsn_gate_eval
    import tsn_gate_pkg::*;
#(
    parameter int NQ     = TSN_NQ,
    parameter int TIME_W = 64,
    parameter int OFF_W  = 32,
    parameter int LEN_W  = 16
) (
    input  logic [TIME_W-1:0]            now_ns,
    input  logic [OFF_W-1:0]             cur_off,
    input  logic [OFF_W-1:0]             act_cycle,
    input  logic [NQ-1:0][OFF_W-1:0]     act_open,
    input  logic [NQ-1:0][OFF_W-1:0]     act_close,
    input  mode_t                        mode,
    input  logic [2:0]                   link_speed,
    input  logic [NQ-1:0]                q_req,
    input  logic [NQ-1:0][LEN_W-1:0]     q_len,
    input  logic [NQ-1:0][TIME_W-1:0]    q_launch,
    output logic [NQ-1:0]                eligible
);
    localparam int SW = OFF_W + 1;

    logic [TIME_W-1:0] now_adj;
    assign now_adj = now_ns + TIME_W'(tx_offset(link_speed));

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic [31:0]   dur;
        logic [SW-1:0] fin;
        logic          in_win, end_ok, cyc_ok, launch_ok;

        assign dur       = frame_ns(32'(q_len[q]), link_speed);
        assign fin       = SW'(cur_off) + SW'(dur);
        assign in_win    = (cur_off >= act_open[q]) && (cur_off < act_close[q]);
        assign end_ok    = !mode.strict_end   || (fin <= SW'(act_close[q]));
        assign cyc_ok    = !mode.strict_cycle || (fin <= SW'(act_cycle));
        assign launch_ok = !mode.launch_en[q] || (now_adj >= q_launch[q]);
        assign eligible[q] = q_req[q] &&
                             (!mode.tsn_en || (in_win && end_ok && cyc_ok && launch_ok));
    end

endmodule

// File: rtl/tsn_prio_pick.sv
module tsn_prio_pick
    import tsn_gate_pkg::*;
#(
    parameter int NQ = TSN_NQ
) (
    input  logic [NQ-1:0]                 eligible,
    input  logic [NQ-1:0][$clog2(NQ)-1:0] prio_map,
    output logic [NQ-1:0]                 pick
);
    // walk from the lowest slot up so that slot 0 overrides everything
    always_comb begin
        pick = '0;
        for (int k = NQ - 1; k >= 0; k--) begin
            if (eligible[prio_map[k]]) begin
                pick = '0;
                pick[prio_map[k]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsn_gate_sched.sv
module tsn_gate_sched
    import tsn_gate_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int OFF_W  = 32,
    parameter int LEN_W  = 16,
    parameter int AW     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [AW-1:0]                 cfg_addr,
    input  logic [OFF_W-1:0]              cfg_wdata,
    input  logic [TIME_W-1:0]             now_ns,
    input  logic [2:0]                    link_speed,
    input  logic [TSN_NQ-1:0]             q_req,
    input  logic [TSN_NQ-1:0][LEN_W-1:0]  q_len,
    input  logic [TSN_NQ-1:0][TIME_W-1:0] q_launch,
    output logic [TSN_NQ-1:0]             grant,
    output logic                          start
);
    localparam int NQ = TSN_NQ;
    localparam int QW = $clog2(NQ);

    logic [NQ-1:0][OFF_W-1:0] act_open, act_close;
    logic [OFF_W-1:0]         act_cycle, cur_off;
    logic [TIME_W-1:0]        pend_base;
    logic [NQ-1:0][QW-1:0]    prio_map;
    logic [NQ-1:0]            eligible, pick;
    logic                     tsn_on;
    mode_t                    mode;

    assign tsn_on = mode.tsn_en;

    tsn_sched_regs #(.NQ(NQ), .TIME_W(TIME_W), .OFF_W(OFF_W), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .now_ns(now_ns), .act_open(act_open), .act_close(act_close), .act_cycle(act_cycle),
        .cur_off(cur_off), .mode(mode), .prio_map(prio_map), .pend_base(pend_base)
    );

    tsn_gate_eval #(.NQ(NQ), .TIME_W(TIME_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_eval (
        .now_ns(now_ns), .cur_off(cur_off), .act_cycle(act_cycle), .act_open(act_open),
        .act_close(act_close), .mode(mode), .link_speed(link_speed), .q_req(q_req),
        .q_len(q_len), .q_launch(q_launch), .eligible(eligible)
    );

    tsn_prio_pick #(.NQ(NQ)) u_pick (
        .eligible(eligible), .prio_map(prio_map), .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= '0;
            start <= 1'b0;
        end else begin
            grant <= pick;
            start <= |pick;
        end
    end

endmodule

// File: rtl/tsn_gate_sched_chk.sv
module tsn_gate_sched_chk #(
    parameter int NQ     = 4,
    parameter int TIME_W = 64,
    parameter int OFF_W  = 32,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [AW-1:0]     cfg_addr,
    input logic [TIME_W-1:0] now_ns,
    input logic [NQ-1:0]     q_req,
    input logic [NQ-1:0]     grant,
    input logic              start,
    input logic              tsn_en,
    input logic [OFF_W-1:0]  cur_off,
    input logic [OFF_W-1:0]  act_cycle,
    input logic [TIME_W-1:0] pend_base
);
    localparam logic [AW-1:0] A_BNS = AW'(2*NQ + 2);

    logic commit_wr;
    assign commit_wr = cfg_we && (cfg_addr == A_BNS);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("grant not one-hot"); // R12

    AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((grant & $past(q_req)) == grant)) else $error("grant without request"); // R12

    AST_PLAIN_MODE_SERVES: assert property (@(posedge clk) disable iff (rst)
        (!tsn_en && (q_req != '0)) |=> start) else $error("plain mode request not served"); // R2

    AST_OFFSET_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cur_off < act_cycle) else $error("cycle offset out of range"); // R4

    AST_ARMED_BASE_AHEAD: assert property (@(posedge clk) disable iff (rst)
        commit_wr |=> (pend_base >= $past(now_ns))) else $error("armed base in the past"); // R11

endmodule

bind tsn_gate_sched tsn_gate_sched_chk u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .now_ns(now_ns),
    .q_req(q_req), .grant(grant), .start(start), .tsn_en(tsn_on), .cur_off(cur_off),
    .act_cycle(act_cycle), .pend_base(pend_base)
);

// File: tb/tsn_gate_sched_tb.sv
module tsn_gate_sched_tb;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [63:0]      now_ns = '0;
    logic [2:0]       link_speed = 3'd2;
    logic [3:0]       q_req = '0;
    logic [3:0][15:0] q_len;
    logic [3:0][63:0] q_launch;
    logic [3:0]       grant;
    logic             start;

    int n_checks = 0;
    int n_fail   = 0;

    // model of the configuration written so far
    logic             m_tsn = 0, m_send = 0, m_scyc = 0;
    logic [3:0]       m_lmask = '0;
    logic [3:0][1:0]  m_map = {2'd3, 2'd2, 2'd1, 2'd0};
    longint unsigned  act_base = 0, act_cyc = 64'd1_000_000_000;
    longint unsigned  act_open [4] = '{0, 0, 0, 0};
    longint unsigned  act_close[4] = '{64'd1_000_000_000, 64'd1_000_000_000,
                                       64'd1_000_000_000, 64'd1_000_000_000};
    longint unsigned  st_open [4] = '{0, 200, 500, 600};
    longint unsigned  st_close[4] = '{300, 500, 750, 1200};
    longint unsigned  t = 0;

    tsn_gate_sched u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .now_ns(now_ns), .link_speed(link_speed), .q_req(q_req), .q_len(q_len),
        .q_launch(q_launch), .grant(grant), .start(start)
    );

    always #5 clk = ~clk;

    function automatic longint unsigned dur_of(input longint unsigned len, input logic [2:0] spd);
        longint unsigned b;
        b = len + 20;
        case (spd)
            3'd1: return b * 80;
            3'd2: return b * 8;
            3'd3: return (b * 16 + 4) / 5;
            default: return b * 800;
        endcase
    endfunction

    function automatic longint unsigned ofs_of(input logic [2:0] spd);
        case (spd)
            3'd0: return 9600;
            3'd1: return 960;
            3'd2: return 160;
            3'd3: return 64;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] model(input longint unsigned tn, input logic [3:0] rq);
        logic [3:0] el;
        logic [3:0] res;
        longint unsigned off;
        longint unsigned d;
        off = (tn - act_base) % act_cyc;
        for (int q = 0; q < 4; q++) begin
            d = dur_of(longint'(q_len[q]), link_speed);
            el[q] = rq[q];
            if (m_tsn) begin
                if (!(off >= act_open[q] && off < act_close[q])) el[q] = 1'b0;
                if (m_send && (off + d > act_close[q]))          el[q] = 1'b0;
                if (m_scyc && (off + d > act_cyc))               el[q] = 1'b0;
                if (m_lmask[q] && (tn + ofs_of(link_speed) < q_launch[q])) el[q] = 1'b0;
            end
        end
        res = '0;
        for (int k = 3; k >= 0; k--)
            if (el[m_map[k]]) begin
                res = '0;
                res[m_map[k]] = 1'b1;
            end
        return res;
    endfunction

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // register write per R13 address map
    task automatic wr(input int a, input longint unsigned d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_mode(input logic tsn, input logic se, input logic sc, input logic [3:0] lm);
        wr(11, {25'd0, lm, sc, se, tsn});
        m_tsn = tsn; m_send = se; m_scyc = sc; m_lmask = lm;
    endtask

    task automatic step(input longint unsigned tn, input logic [3:0] rq);
        @(negedge clk);
        now_ns = tn; q_req = rq; t = tn;
        @(posedge clk); #1;
    endtask

    task automatic advance_to(input longint unsigned target);
        while (t < target) step((t + 900 < target) ? t + 900 : target, 4'b0000);
    endtask

    task automatic apply(input longint unsigned tn, input logic [3:0] rq, input string tag);
        logic [3:0] exp;
        step(tn, rq);
        exp = model(tn, rq);
        n_checks++;
        if (grant !== exp || start !== (|exp)) begin
            n_fail++;
            $display("FAIL %s R12 t=%0d req=%b: grant=%b start=%b expected grant=%b start=%b",
                     tag, tn, rq, grant, start, exp, |exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        longint unsigned cs, x;
        q_len    = {16'd50, 16'd5, 16'd30, 16'd10};
        q_launch = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        n_checks++;
        if (grant !== 4'b0 || start !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: grant=%b start=%b expected grant=0000 start=0", grant, start);
        end
        apply(100, 4'b0000, "R1 idle");
        // R1 defaults: gating on with reset windows keeps every gate open
        wr_mode(1, 0, 0, 4'b0);
        apply(300, 4'b1111, "R1 default open");
        apply(400, 4'b0100, "R1 default open q2");
        wr_mode(0, 0, 0, 4'b0);
        apply(500, 4'b1010, "R2 R3 identity map");
        wr(12, 8'h1B); m_map = {2'd0, 2'd1, 2'd2, 2'd3};
        apply(600, 4'b1010, "R3 reversed map");
        apply(700, 4'b0011, "R3 reversed map low");
        wr(12, 8'hE4); m_map = {2'd3, 2'd2, 2'd1, 2'd0};
        // stage the schedule (R13)
        for (int q = 0; q < 4; q++) begin
            wr(q, st_open[q]);
            wr(4 + q, st_close[q]);
        end
        wr(8, 1000);
        wr(9, 0);
        step(12345, 4'b0000);
        wr(10, 2000);                       // past base, realigned to 13000 (R11)
        wr_mode(1, 0, 0, 4'b0);
        apply(12990, 4'b0010, "R10 old schedule before base");
        step(13000, 4'b0000);
        act_base = 13000; act_cyc = 1000;
        for (int q = 0; q < 4; q++) begin act_open[q] = st_open[q]; act_close[q] = st_close[q]; end
        apply(13005, 4'b0010, "R11 realigned window closed");
        apply(13010, 4'b0001, "R11 realigned window open");
        apply(13260, 4'b0010, "R4 q1 window");
        // sweeps: strict rule mixes x link speeds x request patterns
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int sp = 1; sp <= 3; sp++) begin
                link_speed = 3'(sp);
                wr_mode(1, cfg[0], cfg[1], 4'b0);
                for (int i = 0; i < 300; i++)
                    apply(t + 13, 4'((i * 7 + 3) % 16),
                          $sformatf("R4 R5 R6 R9 sweep cfg=%0d spd=%0d", cfg, sp));
            end
        end
        // plain mode ignores the closed window of q1
        wr_mode(0, 0, 0, 4'b0);
        cs = act_base + ((t - act_base) / 1000 + 1) * 1000;
        apply(cs + 50, 4'b0010, "R2 plain mode ignores window");
        // launch time on q1
        link_speed = 3'd2;
        wr_mode(1, 0, 0, 4'b0010);
        cs = cs + 1000;
        q_launch[1] = cs + 460;
        apply(cs + 299, 4'b0010, "R7 R8 before launch 1000M");
        apply(cs + 300, 4'b0010, "R7 R8 at launch 1000M");
        link_speed = 3'd5;
        apply(cs + 459, 4'b0010, "R8 unknown speed early");
        apply(cs + 460, 4'b0010, "R8 unknown speed at launch");
        cs = cs + 1000;
        q_launch[1] = cs + 400;
        link_speed = 3'd3;
        apply(cs + 335, 4'b0010, "R8 2500M early");
        apply(cs + 336, 4'b0010, "R8 2500M at launch");
        // future commit with a longer cycle
        wr_mode(1, 0, 0, 4'b0);
        link_speed = 3'd2;
        wr(8, 2000);
        x = cs + 3500;
        wr(10, x);
        advance_to(x - 400);
        apply(x - 200, 4'b0001, "R10 old schedule holds");
        step(x, 4'b0000);
        act_base = x; act_cyc = 2000;
        apply(x + 100, 4'b0001, "R10 new schedule");
        apply(x + 2050, 4'b0001, "R10 new cycle length");
        report();
        $finish;
    end

endmodule